// File: doc/BRIEF.md
# Multiword DMA Host Burst Engine

This block is the host side of a 16-bit disk-interface DMA burst in multiword mode 0 or mode 1. Software-side control logic arms it with a direction, a word count and a timing mode. The engine then waits for the device's request line and answers with an acknowledge that it holds for the whole burst. Under that acknowledge it issues one read or write strobe per word. Every strobe phase lasts a whole number of clock ticks. The tick counts come from nanosecond minimums rounded up by a clock-period parameter.

Write words arrive on a valid/ready sink port. A strobe starts only in a cycle where `s_valid_i` is high and `s_ready_o` is high, and that cycle consumes the word. `s_ready_o` never depends on `s_valid_i`. Read words leave on a valid/ready source port backed by a single register. `m_valid_o` stays high and `m_data_o` stays stable until `m_ready_i` is seen. No new read strobe starts while that register is full, so a slow sink stalls the bus rather than losing a word.

The device may pause the burst by lowering its request. The engine then stops launching strobes until the request returns, and it keeps the acknowledge high meanwhile. After the last word, or at the first strobe boundary after an abort, the acknowledge is held for its minimum hold time and then released. A one-cycle done pulse marks the end of the burst.

Top module: `mdma_host_engine`

## Requirements
- R1: An arm pulse starts a burst only when the engine is idle and the word count is nonzero. An arm pulse with a zero count, or any arm pulse while busy, has no effect.
- R2: The acknowledge rises only after the synchronized request has been seen high. It then stays high through any pause until the burst's closing hold ends.
- R3: Each strobe is high for exactly the active tick count: 27 ticks in mode 0 and 10 ticks in mode 1 at an 8 ns clock. This is the larger of the rounded active-width minimum (215/80 ns) and the rounded read access time (150/60 ns).
- R4: Between back-to-back strobes the strobe is low for 33 ticks in mode 0 and 9 ticks in mode 1. This is the largest of three values: the rounded negated minimum (read 50 ns; write 215/50 ns), the rounded cycle minimum (480/150 ns) minus the active ticks, and the write data hold.
- R5: On writes, each strobe consumes one sink word. That word is driven on `bus_dout_o` with `bus_oe_o` high from the strobe's first cycle until after the strobe falls. Words go out in arrival order.
- R6: On reads, `bus_din_i` is captured on the strobe's last high cycle. The word is offered on `m_data_o`/`m_valid_o` and held until accepted, and no read strobe starts while a word is pending.
- R7: While the synchronized request is low, no new strobe starts and the acknowledge stays high. Strobes resume after the request returns.
- R8: Exactly the armed number of strobes is issued. After the last strobe falls, the acknowledge stays high for 3 ticks (mode 0) or 2 ticks (mode 1), then drops, and `done_o` pulses for one cycle with the acknowledge low.
- R9: An abort ends the burst at the next strobe boundary. A strobe in progress completes, no further strobe starts, and the closing hold and done pulse follow.
- R10: The request input passes through a two-flop synchronizer. After the request rises, the acknowledge is still low two cycles later and rises on the third clock edge.
- R11: After reset the acknowledge, both strobes, `bus_oe_o`, `m_valid_o`, `busy_o` and `done_o` are all low.
- R12: Read and write strobes are never high together, and neither is high without the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle pulse that starts a burst |
| arm_write_i | input | 1 | Direction at arm: 1 = write to device, 0 = read |
| arm_mode_i | input | 1 | Timing mode at arm: 0 or 1 |
| arm_words_i | input | CNT_W | Word count at arm |
| abort_i | input | 1 | End the burst at the next strobe boundary |
| dev_req_i | input | 1 | Device request line, asynchronous |
| host_ack_o | output | 1 | Host acknowledge, high during the burst |
| rd_stb_o | output | 1 | Read strobe, high = asserted |
| wr_stb_o | output | 1 | Write strobe, high = asserted |
| bus_dout_o | output | DATA_W | Write data toward the device |
| bus_oe_o | output | 1 | Enables the write data driver |
| bus_din_i | input | DATA_W | Read data from the device |
| s_valid_i | input | 1 | Write sink: word valid |
| s_ready_o | output | 1 | Write sink: engine takes the word this cycle |
| s_data_i | input | DATA_W | Write sink: word |
| m_valid_o | output | 1 | Read source: word valid |
| m_ready_i | input | 1 | Read source: consumer accepts |
| m_data_o | output | DATA_W | Read source: word |
| busy_o | output | 1 | Burst armed and not finished |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
The assertions take several things about the inputs for granted. The device drops its request soon after a strobe, so the two-flop delay is absorbed before the strobe-low phase ends. Read data settles within the access time after the read strobe rises. Mode and direction change only at arm time, since the engine latches them there. The bench's device model respects all of these. It lowers the request only inside a strobe-low gap and drives read data one cycle after each read strobe rises. The sink and source models change `s_valid_i` and `m_ready_i` only on the falling clock edge. Pauses, back-pressure and abort are each applied at a strobe boundary the bench has already observed.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

  // Per-mode timing minimums in nanoseconds, index = mode
  localparam int unsigned CYCLE_NS  [2] = '{480, 150};
  localparam int unsigned STROBE_NS [2] = '{215, 80};
  localparam int unsigned RDNEG_NS  [2] = '{50, 50};
  localparam int unsigned WRNEG_NS  [2] = '{215, 50};
  localparam int unsigned ACCESS_NS [2] = '{150, 60};
  localparam int unsigned WHOLD_NS  [2] = '{20, 15};
  localparam int unsigned ACKHOLD_NS[2] = '{20, 5};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GAP,
    ST_ACT,
    ST_HOLD
  } eng_state_e;

  function automatic int unsigned ns2tk(input int unsigned ns, input int unsigned per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int unsigned tmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mdma_sync.sv
module mdma_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mdma_timing.sv
module mdma_timing
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned TICK_W        = 8
) (
  input  logic              mode_i,
  output logic [TICK_W-1:0] act_o,
  output logic [TICK_W-1:0] rd_neg_o,
  output logic [TICK_W-1:0] wr_neg_o,
  output logic [TICK_W-1:0] hold_o
);
  localparam int unsigned NMODES = 2;

  logic [TICK_W-1:0] act_t  [NMODES];
  logic [TICK_W-1:0] rdn_t  [NMODES];
  logic [TICK_W-1:0] wrn_t  [NMODES];
  logic [TICK_W-1:0] hold_t [NMODES];

  for (genvar m = 0; m < NMODES; m++) begin : g_mode
    localparam int unsigned CYC  = ns2tk(CYCLE_NS[m], CLK_PERIOD_NS);
    localparam int unsigned ACT  = tmax(ns2tk(STROBE_NS[m], CLK_PERIOD_NS),
                                        ns2tk(ACCESS_NS[m], CLK_PERIOD_NS));
    localparam int unsigned REST = (CYC > ACT) ? (CYC - ACT) : 0;
    localparam int unsigned WHLD = ns2tk(WHOLD_NS[m], CLK_PERIOD_NS);
    localparam int unsigned RNEG = tmax(ns2tk(RDNEG_NS[m], CLK_PERIOD_NS), REST);
    localparam int unsigned WNEG = tmax(tmax(ns2tk(WRNEG_NS[m], CLK_PERIOD_NS), REST), WHLD);
    localparam int unsigned HLD  = tmax(tmax(ns2tk(ACKHOLD_NS[m], CLK_PERIOD_NS), WHLD), 1);
    assign act_t[m]  = TICK_W'(ACT);
    assign rdn_t[m]  = TICK_W'(RNEG);
    assign wrn_t[m]  = TICK_W'(WNEG);
    assign hold_t[m] = TICK_W'(HLD);
  end

  assign act_o    = act_t[mode_i];
  assign rd_neg_o = rdn_t[mode_i];
  assign wr_neg_o = wrn_t[mode_i];
  assign hold_o   = hold_t[mode_i];
endmodule

// File: rtl/mdma_word_ctr.sv
module mdma_word_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rem_q <= '0;
    else if (load_i)             rem_q <= load_val_i;
    else if (dec_i && rem_q != 0) rem_q <= rem_q - 1'b1;
  end

  assign last_o  = (rem_q == CNT_W'(1));
  assign empty_o = (rem_q == '0);
endmodule

// File: rtl/mdma_host_engine.sv
module mdma_host_engine
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned TICK_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              arm_write_i,
  input  logic              arm_mode_i,
  input  logic [CNT_W-1:0]  arm_words_i,
  input  logic              abort_i,
  input  logic              dev_req_i,
  output logic              host_ack_o,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_din_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              busy_o,
  output logic              done_o
);

  eng_state_e        state_q, state_d;
  logic [TICK_W-1:0] tmr_q, tmr_d;
  logic              dir_wr_q, mode_q, abort_q, done_q;
  logic              m_valid_q;
  logic [DATA_W-1:0] m_data_q, dout_q;
  logic              req_s;
  logic [TICK_W-1:0] act_t, rd_neg_t, wr_neg_t, hold_t, neg_t;
  logic              ctr_last, ctr_empty;
  logic              start, gap_ready, can_go, wr_go, rd_go, go, act_end;

  // Request synchronizer
  mdma_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dev_req_i),
    .q_o   (req_s)
  );

  // Mode-dependent tick counts
  mdma_timing #(.CLK_PERIOD_NS(CLK_PERIOD_NS), .TICK_W(TICK_W)) u_timing (
    .mode_i  (mode_q),
    .act_o   (act_t),
    .rd_neg_o(rd_neg_t),
    .wr_neg_o(wr_neg_t),
    .hold_o  (hold_t)
  );

  assign neg_t = dir_wr_q ? wr_neg_t : rd_neg_t;

  // Remaining-word counter
  mdma_word_ctr #(.CNT_W(CNT_W)) u_words (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start),
    .load_val_i(arm_words_i),
    .dec_i     (act_end),
    .last_o    (ctr_last),
    .empty_o   (ctr_empty)
  );

  assign start     = (state_q == ST_IDLE) && arm_i && (arm_words_i != '0);
  assign gap_ready = (state_q == ST_GAP) && (tmr_q == '0);
  assign can_go    = gap_ready && !abort_q && req_s && !ctr_empty;
  assign s_ready_o = can_go && dir_wr_q;
  assign wr_go     = s_ready_o && s_valid_i;
  assign rd_go     = can_go && !dir_wr_q && !m_valid_q;
  assign go        = wr_go || rd_go;
  assign act_end   = (state_q == ST_ACT) && (tmr_q == '0);

  always_comb begin
    state_d = state_q;
    tmr_d   = (tmr_q == '0) ? '0 : tmr_q - 1'b1;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_WAIT;
      ST_WAIT: begin
        if (abort_q) begin
          state_d = ST_IDLE;
        end else if (req_s) begin
          state_d = ST_GAP;
          tmr_d   = '0;
        end
      end
      ST_GAP: begin
        if (gap_ready && (abort_q || ctr_empty)) begin
          state_d = ST_HOLD;
          tmr_d   = hold_t - 1'b1;
        end else if (go) begin
          state_d = ST_ACT;
          tmr_d   = act_t - 1'b1;
        end
      end
      ST_ACT: begin
        if (act_end) begin
          if (ctr_last) begin
            state_d = ST_HOLD;
            tmr_d   = hold_t - 1'b1;
          end else begin
            state_d = ST_GAP;
            tmr_d   = neg_t - 1'b1;
          end
        end
      end
      ST_HOLD: if (tmr_q == '0) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      dir_wr_q <= 1'b0;
      mode_q   <= 1'b0;
      abort_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      done_q  <= ((state_q == ST_HOLD) && (tmr_q == '0)) ||
                 ((state_q == ST_WAIT) && abort_q);
      if (start) begin
        dir_wr_q <= arm_write_i;
        mode_q   <= arm_mode_i;
      end
      if (state_q == ST_IDLE) abort_q <= 1'b0;
      else if (abort_i)       abort_q <= 1'b1;
    end
  end

  // Write data register, loaded as the strobe starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dout_q <= '0;
    else if (wr_go) dout_q <= s_data_i;
  end

  // Read holding register with valid/ready output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_valid_q <= 1'b0;
      m_data_q  <= '0;
    end else if (act_end && !dir_wr_q) begin
      m_valid_q <= 1'b1;
      m_data_q  <= bus_din_i;
    end else if (m_valid_q && m_ready_i) begin
      m_valid_q <= 1'b0;
    end
  end

  assign host_ack_o = (state_q == ST_GAP) || (state_q == ST_ACT) || (state_q == ST_HOLD);
  assign rd_stb_o   = (state_q == ST_ACT) && !dir_wr_q;
  assign wr_stb_o   = (state_q == ST_ACT) && dir_wr_q;
  assign bus_oe_o   = host_ack_o && dir_wr_q;
  assign bus_dout_o = dout_q;
  assign m_valid_o  = m_valid_q;
  assign m_data_o   = m_data_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

endmodule

// File: rtl/mdma_host_engine_chk.sv
module mdma_host_engine_chk
  import mdma_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned DATA_W        = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_stb_i,
  input logic              wr_stb_i,
  input logic              ack_i,
  input logic [DATA_W-1:0] dout_i,
  input logic              oe_i,
  input logic              m_valid_i,
  input logic              m_ready_i,
  input logic [DATA_W-1:0] m_data_i,
  input logic              done_i,
  input logic              req_s_i,
  input logic              mode_i,
  input logic              dir_wr_i
);
  localparam int unsigned SAT = 1023;

  int unsigned hi_cnt, lo_cnt, cyc_cnt;
  logic        stb, stb_q, had_stb;
  int unsigned act_min, neg_min, cyc_min, hold_min;

  assign stb      = rd_stb_i || wr_stb_i;
  assign act_min  = ns2tk(STROBE_NS[mode_i], CLK_PERIOD_NS);
  assign neg_min  = dir_wr_i ? ns2tk(WRNEG_NS[mode_i], CLK_PERIOD_NS)
                             : ns2tk(RDNEG_NS[mode_i], CLK_PERIOD_NS);
  assign cyc_min  = ns2tk(CYCLE_NS[mode_i], CLK_PERIOD_NS);
  assign hold_min = ns2tk(ACKHOLD_NS[mode_i], CLK_PERIOD_NS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= 0;
      lo_cnt  <= 0;
      cyc_cnt <= 0;
      stb_q   <= 1'b0;
      had_stb <= 1'b0;
    end else begin
      stb_q   <= stb;
      hi_cnt  <= stb ? hi_cnt + 1 : 0;
      lo_cnt  <= stb ? 0 : ((lo_cnt < SAT) ? lo_cnt + 1 : lo_cnt);
      cyc_cnt <= (stb && !stb_q) ? 1 : ((cyc_cnt < SAT) ? cyc_cnt + 1 : cyc_cnt);
      had_stb <= ack_i ? (had_stb || stb) : 1'b0;
    end
  end

  a_r12_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i && wr_stb_i));

  a_r12_strobe_under_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb |-> ack_i);

  a_r3_active_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stb && stb_q) |-> (hi_cnt >= act_min));

  a_r4_negated_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !stb_q && had_stb) |-> (lo_cnt >= neg_min));

  a_r4_cycle_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !stb_q && had_stb) |-> (cyc_cnt >= cyc_min));

  a_r7_no_strobe_in_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stb) |-> $past(req_s_i));

  a_r8_ack_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ack_i) && had_stb) |-> (lo_cnt >= hold_min));

  a_r8_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !ack_i);

  a_r6_read_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_i && !m_ready_i) |=> (m_valid_i && $stable(m_data_i)));

  a_r5_write_data_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_i && $past(wr_stb_i)) |-> ($stable(dout_i) && oe_i));

endmodule

bind mdma_host_engine mdma_host_engine_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .DATA_W       (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rd_stb_i (rd_stb_o),
  .wr_stb_i (wr_stb_o),
  .ack_i    (host_ack_o),
  .dout_i   (bus_dout_o),
  .oe_i     (bus_oe_o),
  .m_valid_i(m_valid_o),
  .m_ready_i(m_ready_i),
  .m_data_i (m_data_o),
  .done_i   (done_o),
  .req_s_i  (req_s),
  .mode_i   (mode_q),
  .dir_wr_i (dir_wr_q)
);

// File: tb/mdma_host_engine_tb_top.sv
module mdma_host_engine_tb_top;
  localparam int unsigned WBASE = 16'h3A00;
  localparam int unsigned RBASE = 16'hC100;
  localparam int NVEC = 5;
  // {write, mode, words, exp_active, exp_gap, exp_hold}
  localparam int VEC [NVEC][6] = '{
    '{1, 0, 4, 27, 33, 3},
    '{1, 1, 5, 10,  9, 2},
    '{0, 0, 3, 27, 33, 3},
    '{0, 1, 6, 10,  9, 2},
    '{1, 1, 1, 10,  0, 2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, arm_wr = 0, arm_mode = 0, abort = 0, dev_req = 1;
  logic [15:0] arm_words = '0;
  logic ack, rd_stb, wr_stb, bus_oe, s_ready, m_valid, busy, done;
  logic [15:0] bus_dout, bus_din = '0, s_data, m_data;
  logic s_valid = 1, sink_ready = 1;

  int checks = 0, errors = 0;
  int stb_cnt, act_min, act_max, act_run, low_run, gap_min, hold_meas, done_cnt;
  int wr_seen = 0, wr_err = 0, rd_issued = 0, rd_err = 0, rcv = 0, src_idx = 0;
  logic prev_stb = 0, prev_wr = 0, prev_ack = 0, stb_now;
  logic [15:0] last_wd = '0;

  always #4 clk = ~clk;

  mdma_host_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .arm_i(arm), .arm_write_i(arm_wr), .arm_mode_i(arm_mode), .arm_words_i(arm_words),
    .abort_i(abort), .dev_req_i(dev_req), .host_ack_o(ack),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .bus_dout_o(bus_dout), .bus_oe_o(bus_oe),
    .bus_din_i(bus_din), .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .m_valid_o(m_valid), .m_ready_i(sink_ready), .m_data_o(m_data),
    .busy_o(busy), .done_o(done)
  );

  // Write source and read sink
  assign s_data = 16'(WBASE + src_idx);
  always @(posedge clk) begin
    if (s_valid && s_ready) src_idx <= src_idx + 1;
    if (m_valid && sink_ready) begin
      if (m_data != 16'(RBASE + rcv)) rd_err <= rd_err + 1;
      rcv <= rcv + 1;
    end
  end

  // Device model and bus monitor
  assign stb_now = rd_stb || wr_stb;
  always @(negedge clk) begin
    if (stb_now) begin
      if (!prev_stb) begin
        if (stb_cnt > 0 && low_run < gap_min) gap_min = low_run;
        stb_cnt++;
        if (rd_stb) begin
          bus_din = 16'(RBASE + rd_issued);
          rd_issued++;
        end
      end
      act_run++;
      if (wr_stb) last_wd = bus_dout;
    end else begin
      if (prev_stb) begin
        if (act_run < act_min) act_min = act_run;
        if (act_run > act_max) act_max = act_run;
        act_run = 0;
        low_run = 0;
        if (prev_wr) begin
          if (!bus_oe || bus_dout != last_wd || last_wd != 16'(WBASE + wr_seen)) wr_err++;
          wr_seen++;
        end
      end
      if (ack) low_run++;
    end
    if (prev_ack && !ack) hold_meas = low_run;
    if (done) done_cnt++;
    prev_stb = stb_now;
    prev_wr  = wr_stb;
    prev_ack = ack;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    stb_cnt = 0; act_min = 9999; act_max = 0; act_run = 0; low_run = 0;
    gap_min = 9999; hold_meas = -1; done_cnt = 0;
  endtask

  task automatic arm_burst(input bit wr, input bit mode, input int words);
    @(negedge clk);
    arm_wr = wr; arm_mode = mode; arm_words = 16'(words); arm = 1;
    @(negedge clk);
    arm = 0;
  endtask

  task automatic wait_done(input string req);
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    chk(done_cnt == 1, req, done_cnt, 1);
    @(negedge clk);
  endtask

  task automatic wait_strobes(input int n);
    for (int i = 0; i < 5000 && !(stb_cnt == n && !stb_now); i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int exp_first;
    mon_clear();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!ack && !rd_stb && !wr_stb && !bus_oe, "R11 bus idle in reset", ack, 0);
    chk(!m_valid && !busy && !done, "R11 status idle in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!ack && !busy, "R11 idle after reset release", busy, 0);

    // Vector table: R3 R4 R5 R6 R8
    for (int v = 0; v < NVEC; v++) begin
      mon_clear();
      arm_burst(VEC[v][0] != 0, VEC[v][1] != 0, VEC[v][2]);
      wait_done("R8 done pulse");
      chk(stb_cnt == VEC[v][2], "R8 strobe count", stb_cnt, VEC[v][2]);
      chk(act_min == VEC[v][3] && act_max == VEC[v][3], "R3 active ticks", act_max, VEC[v][3]);
      if (VEC[v][2] > 1) chk(gap_min == VEC[v][4], "R4 negated ticks", gap_min, VEC[v][4]);
      chk(hold_meas == VEC[v][5], "R8 ack hold ticks", hold_meas, VEC[v][5]);
      chk(!ack && !busy, "R8 released", ack, 0);
    end
    chk(wr_err == 0 && wr_seen == 10, "R5 write words", wr_err, 0);
    chk(rd_err == 0 && rcv == 9, "R6 read words", rcv, 9);

    // R1 zero count ignored
    mon_clear();
    arm_burst(1, 1, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !ack && stb_cnt == 0, "R1 zero count ignored", busy, 0);

    // R10 / R2: synchronizer latency, no ack before request
    mon_clear();
    dev_req = 0;
    arm_burst(1, 1, 2);
    repeat (10) @(negedge clk);
    chk(!ack && busy, "R2 no ack without request", ack, 0);
    dev_req = 1;
    repeat (2) @(negedge clk);
    chk(!ack, "R10 ack low two cycles after request", ack, 0);
    @(negedge clk);
    chk(ack, "R10 ack on third edge", ack, 1);
    wait_done("R10 burst done");
    chk(stb_cnt == 2, "R10 strobe count", stb_cnt, 2);

    // R7 pause, with R1 arm-while-busy ignored
    mon_clear();
    arm_burst(1, 1, 6);
    wait_strobes(2);
    dev_req = 0;
    arm_burst(0, 0, 1);
    repeat (40) @(negedge clk);
    chk(stb_cnt == 2, "R7 no strobe while paused", stb_cnt, 2);
    chk(ack, "R7 ack held in pause", ack, 1);
    dev_req = 1;
    wait_done("R7 resume done");
    chk(stb_cnt == 6, "R1 arm while busy ignored", stb_cnt, 6);
    chk(wr_err == 0, "R5 write words after pause", wr_err, 0);

    // R6 back-pressure
    mon_clear();
    sink_ready = 0;
    exp_first = RBASE + rd_issued;
    arm_burst(0, 1, 3);
    repeat (60) @(negedge clk);
    chk(stb_cnt == 1, "R6 stall on full output", stb_cnt, 1);
    chk(m_valid && m_data == 16'(exp_first), "R6 word held", m_data, exp_first);
    sink_ready = 1;
    wait_done("R6 done");
    chk(stb_cnt == 3 && rd_err == 0 && rcv == 12, "R6 words after stall", rcv, 12);

    // R9 abort at strobe boundary
    mon_clear();
    arm_burst(1, 0, 10);
    wait_strobes(2);
    abort = 1;
    @(negedge clk);
    abort = 0;
    wait_done("R9 abort done");
    chk(stb_cnt == 2, "R9 strobes after abort", stb_cnt, 2);
    chk(!ack && !busy, "R9 released after abort", ack, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule